// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a conditional branch is taken and computes the next program counter. It holds a four-bit condition code register that captures the carry, zero, negative and overflow flags produced elsewhere in the pipeline. Flags are captured only when an update strobe is high. The branch decision itself is combinational. It is formed from the registered flags, a four-bit condition select and a branch-instruction strobe.

The block covers sixteen conditions. They include the plain single-flag tests, the unsigned relations (higher, lower-or-same) and the signed relations (greater-or-equal, less-than, greater-than, less-or-equal), plus always and never. Conditions come in pairs: each odd code is the exact complement of the even code just below it. When the selected condition holds and the branch strobe is high, the next PC is the instruction's target address. Otherwise the next PC is the current PC plus a fixed step. The flag interface and branch interface are plain control pins with no handshake; both are sampled every cycle.

Top module: `brcond_unit`

## Requirements
- R1: An active-low asynchronous reset clears the condition register `ccr_q` to 4'b0000. Its bit layout is [3]=N, [2]=Z, [1]=V, [0]=C, and `flag_in` uses the same layout.
- R2: At a rising clock edge with `flag_we` high, all four bits of `flag_in` load into `ccr_q` together. With `flag_we` low, `ccr_q` keeps its value.
- R3: The `br_cond` codes for single-flag tests are as follows. 4 is carry clear (C=0) and 5 is carry set (C=1). 6 is not-equal (Z=0) and 7 is equal (Z=1). 8 is overflow clear (V=0) and 9 is overflow set (V=1). 10 is plus (N=0) and 11 is minus (N=1).
- R4: Unsigned codes: 2 is higher, taken when C=0 and Z=0. 3 is lower-or-same, taken when C=1 or Z=1.
- R5: Signed codes: 12 is greater-or-equal, taken when N equals V. 13 is less-than, taken when N differs from V. 14 is greater-than, taken when Z=0 and N equals V. 15 is less-or-equal, taken when Z=1 or N differs from V.
- R6: While `br_valid` is low, `take_br` is 0 and `pc_next` equals `pc_cur + PC_STEP`, whatever the condition and flags.
- R7: `pc_next` equals `br_target` when `take_br` is 1. Otherwise it equals `pc_cur + PC_STEP`, taken modulo 2^AW, so the top address wraps to zero.
- R8: A branch is judged on the flags held in `ccr_q` before the current clock edge. A flag load in the same cycle affects only branches in later cycles.
- R9: Branch activity (`br_valid`, `br_cond`, `pc_cur`, `br_target`) never changes `ccr_q`.
- R10: Code 0 (always) is taken whenever `br_valid` is high. Code 1 (never) is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Flag update strobe |
| flag_in | input | 4 | New flags {N,Z,V,C} |
| br_valid | input | 1 | Branch instruction present this cycle |
| br_cond | input | 4 | Condition select code |
| pc_cur | input | AW | Current program counter |
| br_target | input | AW | Address field of the branch instruction |
| take_br | output | 1 | Branch is taken |
| pc_next | output | AW | Next program counter |
| ccr_q | output | 4 | Current condition register {N,Z,V,C} |

## Verification
A flag update and a branch evaluation can occur in the same cycle. This happens when an ALU result and a branch that depends on it arrive back to back. The bench provokes this by raising `flag_we` with a new zero flag while an equal-branch is presented. It expects the branch to be judged on the old flags in that cycle and on the new flags one cycle later. The vector walk also covers flag loads interleaved with branch sweeps, and checks that the register is unchanged after each sweep.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned NUM_COND = 1 << COND_W;
  localparam int unsigned NUM_PAIR = NUM_COND / 2;

  // Odd codes are the complement of the even code below them.
  typedef enum logic [COND_W-1:0] {
    CND_ALWAYS = 4'd0,  CND_NEVER = 4'd1,
    CND_HI     = 4'd2,  CND_LS    = 4'd3,
    CND_CC     = 4'd4,  CND_CS    = 4'd5,
    CND_NE     = 4'd6,  CND_EQ    = 4'd7,
    CND_VC     = 4'd8,  CND_VS    = 4'd9,
    CND_PL     = 4'd10, CND_MI    = 4'd11,
    CND_GE     = 4'd12, CND_LT    = 4'd13,
    CND_GT     = 4'd14, CND_LE    = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/brcond_flag_reg.sv
module brcond_flag_reg
  import brcond_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  ccr_t d,
  output ccr_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/brcond_decide.sv
module brcond_decide
  import brcond_pkg::*;
(
  input  ccr_t              flags,
  input  logic [COND_W-1:0] sel,
  input  logic              valid,
  output logic              take
);

  logic [NUM_PAIR-1:0] base;
  logic [NUM_COND-1:0] hit;
  logic                n_eq_v;

  assign n_eq_v = ~(flags.n ^ flags.v);

  // Even-code predicates, one per pair.
  always_comb begin
    base[0] = 1'b1;                    // always
    base[1] = ~flags.c & ~flags.z;     // unsigned higher
    base[2] = ~flags.c;                // carry clear
    base[3] = ~flags.z;                // not equal
    base[4] = ~flags.v;                // overflow clear
    base[5] = ~flags.n;                // plus
    base[6] = n_eq_v;                  // signed >=
    base[7] = ~flags.z & n_eq_v;       // signed >
  end

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    assign hit[2*k]   = base[k];
    assign hit[2*k+1] = ~base[k];
  end

  assign take = valid & hit[sel];

endmodule

// File: rtl/brcond_pc_sel.sv
module brcond_pc_sel #(
  parameter int unsigned AW      = 16,
  parameter int unsigned PC_STEP = 1
) (
  input  logic [AW-1:0] pc_cur,
  input  logic [AW-1:0] target,
  input  logic          take,
  output logic [AW-1:0] pc_next
);

  localparam logic [AW-1:0] STEP = AW'(PC_STEP);

  logic [AW-1:0] pc_seq;

  assign pc_seq  = pc_cur + STEP;
  assign pc_next = take ? target : pc_seq;

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned PC_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  input  logic [AW-1:0]     pc_cur,
  input  logic [AW-1:0]     br_target,
  output logic              take_br,
  output logic [AW-1:0]     pc_next,
  output logic [FLAG_W-1:0] ccr_q
);

  ccr_t flags_q;
  ccr_t flags_d;

  assign flags_d = ccr_t'(flag_in);

  brcond_flag_reg u_ccr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .d     (flags_d),
    .q     (flags_q)
  );

  brcond_decide u_decide (
    .flags (flags_q),
    .sel   (br_cond),
    .valid (br_valid),
    .take  (take_br)
  );

  brcond_pc_sel #(
    .AW      (AW),
    .PC_STEP (PC_STEP)
  ) u_pc (
    .pc_cur  (pc_cur),
    .target  (br_target),
    .take    (take_br),
    .pc_next (pc_next)
  );

  assign ccr_q = flags_q;

endmodule

// File: rtl/brcond_chk.sv
module brcond_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned PC_STEP = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flag_we,
  input logic [3:0]    flag_in,
  input logic          br_valid,
  input logic [3:0]    br_cond,
  input logic [AW-1:0] pc_cur,
  input logic [AW-1:0] br_target,
  input logic          take_br,
  input logic [AW-1:0] pc_next,
  input logic [3:0]    ccr_q
);

  localparam logic [AW-1:0] STEP = AW'(PC_STEP);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ccr_q == 4'b0000);

  assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> ccr_q == $past(flag_in));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(ccr_q));

  assert_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == 4'd7) |-> take_br == ccr_q[2]);

  assert_signed_ge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == 4'd12) |-> take_br == (ccr_q[3] == ccr_q[1]));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> (!take_br && pc_next == pc_cur + STEP));

  assert_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |-> pc_next == br_target);

  assert_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond == 4'd1) |-> !take_br);

  assert_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == 4'd0) |-> take_br);

endmodule

bind brcond_unit brcond_chk #(
  .AW      (AW),
  .PC_STEP (PC_STEP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_we   (flag_we),
  .flag_in   (flag_in),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .pc_cur    (pc_cur),
  .br_target (br_target),
  .take_br   (take_br),
  .pc_next   (pc_next),
  .ccr_q     (ccr_q)
);

// File: tb/tb_brcond_unit.sv
`timescale 1ns/1ps
module tb_brcond_unit;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flag_we = 1'b0;
  logic [3:0]    flag_in = '0;
  logic          br_valid = 1'b0;
  logic [3:0]    br_cond = '0;
  logic [AW-1:0] pc_cur = '0;
  logic [AW-1:0] br_target = '0;
  logic          take_br;
  logic [AW-1:0] pc_next;
  logic [3:0]    ccr_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  brcond_unit #(.AW(AW), .PC_STEP(1)) dut (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
    .br_valid(br_valid), .br_cond(br_cond), .pc_cur(pc_cur),
    .br_target(br_target), .take_br(take_br), .pc_next(pc_next),
    .ccr_q(ccr_q)
  );

  // {flags N,Z,V,C ; 16-bit mask of taken codes, bit i = code i}
  localparam logic [19:0] VEC [0:8] = '{
    {4'b0000, 16'h5555},
    {4'b0001, 16'h5569},
    {4'b0100, 16'h9599},
    {4'b1000, 16'hA955},
    {4'b0010, 16'hA655},
    {4'b1010, 16'h5A55},
    {4'b1111, 16'h9AA9},
    {4'b0110, 16'hA699},
    {4'b0011, 16'hA669}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_flags(input logic [3:0] f);
    @(negedge clk);
    flag_in = f;
    flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  function automatic string cond_req(input int c);
    if (c < 2) return "R10";
    if (c < 4) return "R4";
    if (c >= 12) return "R5";
    return "R3";
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Reset state R1
    repeat (3) @(negedge clk);
    #1;
    check(ccr_q == 4'b0000, "R1 reset ccr", ccr_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ccr_q == 4'b0000, "R1 after release", ccr_q, 0);

    // Vector walk over flag patterns and all codes
    for (int v = 0; v < 9; v++) begin
      logic [3:0]  f;
      logic [15:0] m;
      f = VEC[v][19:16];
      m = VEC[v][15:0];
      load_flags(f);
      #1;
      check(ccr_q == f, "R2 load", ccr_q, f);
      for (int c = 0; c < 16; c++) begin
        logic [AW-1:0] pc;
        logic [AW-1:0] tg;
        @(negedge clk);
        pc = AW'(16'h1000 + v * 16 + c);
        tg = AW'(16'hC000 ^ (v * 256 + c));
        br_valid  = 1'b1;
        br_cond   = 4'(c);
        pc_cur    = pc;
        br_target = tg;
        #1;
        check(take_br == m[c], cond_req(c), take_br, m[c]);
        check(pc_next == (m[c] ? tg : pc + 1'b1), "R7 next pc", pc_next,
              m[c] ? tg : pc + 1'b1);
      end
      @(negedge clk);
      br_valid = 1'b0;
      #1;
      check(ccr_q == f, "R9 ccr untouched by branches", ccr_q, f);
    end

    // R6: strobe low suppresses an always branch
    load_flags(4'b0000);
    @(negedge clk);
    br_valid = 1'b0; br_cond = 4'd0; pc_cur = 16'h1234; br_target = 16'h5678;
    #1;
    check(take_br == 1'b0, "R6 idle take", take_br, 0);
    check(pc_next == 16'h1235, "R6 idle pc", pc_next, 16'h1235);

    // R7: sequential wrap at top of address space
    @(negedge clk);
    br_valid = 1'b1; br_cond = 4'd1; pc_cur = 16'hFFFF;
    #1;
    check(pc_next == 16'h0000, "R7 wrap", pc_next, 0);

    // R8: flag load and equal-branch in the same cycle
    @(negedge clk);
    flag_in = 4'b0100; flag_we = 1'b1;
    br_valid = 1'b1; br_cond = 4'd7; pc_cur = 16'h0200; br_target = 16'h0800;
    #1;
    check(take_br == 1'b0, "R8 same cycle old flags", take_br, 0);
    check(pc_next == 16'h0201, "R8 same cycle pc", pc_next, 16'h0201);
    @(negedge clk);
    flag_we = 1'b0;
    #1;
    check(take_br == 1'b1, "R8 next cycle new flags", take_br, 1);
    check(pc_next == 16'h0800, "R8 next cycle pc", pc_next, 16'h0800);

    // R2: strobe low holds flags
    @(negedge clk);
    flag_in = 4'b1011;
    @(negedge clk);
    #1;
    check(ccr_q == 4'b0100, "R2 hold", ccr_q, 4'b0100);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ccr_q == 4'b0000, "R1 async clear", ccr_q, 0);
    @(negedge clk);
    rst_n = 1'b1;
    br_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule